// File: doc/BRIEF.md
# Scratchpad Mixing Loop Core

This core runs the inner loop of a memory-hard proof-of-work hash. It keeps two 128-bit state words, `a` and `b`, and works against a large scratchpad of 128-bit entries. The scratchpad sits outside the core and is reached through one synchronous port. At its default size the scratchpad holds 2 MB, which is 131072 entries.

Each iteration makes two data-dependent visits to the scratchpad:

1. The core reads the entry selected by state word `a`.
2. It mixes that entry with one bare AES round, using `a` as the round key.
3. It writes part of the result back to the same entry.
4. It uses the round output to choose a second entry and reads it.
5. It folds that second entry in through a 64x64 multiply-add.
6. It writes the updated state to the second entry.

The loop repeats for a programmed number of iterations. The final state words stay on the outputs for a later digest stage.

Filling the scratchpad beforehand is done by other logic, and so is the digest stage. The core only needs a start pulse, an iteration count and the two initial state words. When the run ends it pulses `done`.

Top module: `mixloop_core`

## Requirements
- R1: During reset and after it is released, `busy`, `done`, `mem_en`, `mem_we`, `final_a` and `final_b` are all zero.
- R2: An iteration begins with a read (`mem_en`=1, `mem_we`=0). The read index is `a[ADDR_W+3:4]`. Read data returns on `mem_rdata` one cycle after the read is issued.
- R3: The first entry `x` is mixed into `c`.
  - Byte k of a word is bits [8k+7:8k]. Byte 4*col+row sits at that row and column.
  - The mix applies, in order: the AES S-box to every byte; a left rotation of row r by r columns; MixColumns with rows {2,3,1,1} rotated; then XOR with `a`.
- R4: In the cycle after the first read data returns, the core writes `b ^ c` to the first index. This happens before the second read is issued.
- R5: The second read uses index `c[ADDR_W+3:4]`. It is issued in the cycle after the write-back, so a second index equal to the first returns the value just written.
- R6: Let `p = c[63:0] * y[63:0]` as a full 128-bit product, where `y` is the second entry read. The updated word is `a' = {a[127:64] + p[63:0], a[63:0] + p[127:64]}`, each half taken modulo 2^64. It is written to the second index in the cycle after `y` returns.
- R7: After each iteration, the next `a` is `a' ^ y` and the next `b` is `c`.
- R8: Each iteration takes four cycles. `done` appears 4*N clock edges after the edge that accepts `start`. With N = 0, `done` follows the accepting edge directly and the final words equal the initial words.
- R9: `done` is high for exactly one cycle. `busy` is high from the accepting edge until the `done` cycle, and is low during `done`.
- R10: While the core is idle, `final_a` and `final_b` hold their values until the next accepted `start`.
- R11: A `start` pulse while `busy` is high is ignored. The run in progress completes with its original inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; accepted only while idle |
| iters | input | CNT_W | Number of iterations to run |
| init_a | input | 128 | Initial state word `a` |
| init_b | input | 128 | Initial state word `b` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_en | output | 1 | Scratchpad access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Scratchpad entry index |
| mem_wdata | output | 128 | Write data |
| mem_rdata | input | 128 | Read data, one cycle after the read |
| final_a | output | 128 | State word `a` |
| final_b | output | 128 | State word `b` |

## Verification
The hardest case to reach is an iteration whose second index lands on the first. In that case the second read must return the value just written back, not the original entry. Random scratchpad contents hit this case only by chance.

The bench therefore forces it. It sets `a` to zero, which makes the first index zero. It then searches candidate words until the bench's own AES round maps one of them to a zero index, and plants that word in entry zero. Long runs over a 64-entry scratchpad add further, naturally occurring collisions. Each run is compared against the reference by final state and by the whole memory.

// File: rtl/mixloop_pkg.sv
package mixloop_pkg;

  // Multiply by x in GF(2^8), reduced by the AES polynomial.
  function automatic logic [7:0] gf_xtime(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] p, input logic [7:0] q);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = p;
    for (int i = 0; i < 8; i++) begin
      if (q[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // Multiplicative inverse as v^254; zero maps to zero.
  function automatic logic [7:0] gf_inv(input logic [7:0] v);
    logic [7:0] r;
    logic [7:0] sq;
    r  = 8'h01;
    sq = v;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] v);
    logic [7:0] t;
    t = gf_inv(v);
    return t ^ {t[6:0], t[7]} ^ {t[5:0], t[7:6]} ^ {t[4:0], t[7:5]} ^
           {t[3:0], t[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [127:0] mul64_full(input logic [63:0] p, input logic [63:0] q);
    return {64'd0, p} * {64'd0, q};
  endfunction

endpackage

// File: rtl/mixloop_aes_rnd.sv
module mixloop_aes_rnd (
  input  logic [127:0] blk_i,
  input  logic [127:0] key_i,
  output logic [127:0] blk_o
);
  logic [7:0] sb [16];
  logic [7:0] sr [16];
  logic [7:0] mc [16];

  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sb[4*c+r] = mixloop_pkg::sbox(blk_i[8*(4*c+r) +: 8]);
      assign sr[4*c+r] = sb[4*((c+r)%4)+r];
    end
    for (genvar r = 0; r < 4; r++) begin : g_mix
      localparam int R1I = (r + 1) % 4;
      localparam int R2I = (r + 2) % 4;
      localparam int R3I = (r + 3) % 4;
      assign mc[4*c+r] = mixloop_pkg::gf_xtime(sr[4*c+r]) ^
                         mixloop_pkg::gf_xtime(sr[4*c+R1I]) ^ sr[4*c+R1I] ^
                         sr[4*c+R2I] ^ sr[4*c+R3I];
    end
    for (genvar r = 0; r < 4; r++) begin : g_key
      assign blk_o[8*(4*c+r) +: 8] = mc[4*c+r] ^ key_i[8*(4*c+r) +: 8];
    end
  end
endmodule

// File: rtl/mixloop_mul_step.sv
module mixloop_mul_step (
  input  logic [63:0]  c_lo_i,
  input  logic [63:0]  y_lo_i,
  input  logic [127:0] a_i,
  output logic [127:0] a_o
);
  logic [127:0] prod;
  assign prod = mixloop_pkg::mul64_full(c_lo_i, y_lo_i);
  assign a_o  = {a_i[127:64] + prod[63:0], a_i[63:0] + prod[127:64]};
endmodule

// File: rtl/mixloop_core.sv
module mixloop_core #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  iters,
  input  logic [127:0]      init_a,
  input  logic [127:0]      init_b,
  output logic              busy,
  output logic              done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [127:0]      mem_wdata,
  input  logic [127:0]      mem_rdata,
  output logic [127:0]      final_a,
  output logic [127:0]      final_b
);
  localparam int IDX_LSB = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_RD1, ST_X1, ST_RD2, ST_X2} st_t;

  st_t              st_q;
  logic [127:0]     a_q, b_q, c_q;
  logic [CNT_W-1:0] cnt_q, n_q;
  logic             done_q;

  logic [127:0]     c_w, a_upd;
  logic [ADDR_W-1:0] idx_first, idx_second;
  logic             start_acc, last_iter;
  logic             wr_first, rd_second;

  assign idx_first  = a_q[IDX_LSB +: ADDR_W];
  assign idx_second = c_q[IDX_LSB +: ADDR_W];
  assign start_acc  = start && (st_q == ST_IDLE);
  assign last_iter  = (cnt_q + 1'b1) == n_q;
  assign wr_first   = (st_q == ST_X1);
  assign rd_second  = (st_q == ST_RD2);

  mixloop_aes_rnd u_aes (
    .blk_i (mem_rdata),
    .key_i (a_q),
    .blk_o (c_w)
  );

  mixloop_mul_step u_mul (
    .c_lo_i (c_q[63:0]),
    .y_lo_i (mem_rdata[63:0]),
    .a_i    (a_q),
    .a_o    (a_upd)
  );

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st_q)
      ST_RD1: begin mem_en = 1'b1; mem_addr = idx_first; end
      ST_X1:  begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = idx_first;  mem_wdata = b_q ^ c_w; end
      ST_RD2: begin mem_en = 1'b1; mem_addr = idx_second; end
      ST_X2:  begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = idx_second; mem_wdata = a_upd; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      cnt_q  <= '0;
      n_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_acc) begin
          a_q   <= init_a;
          b_q   <= init_b;
          n_q   <= iters;
          cnt_q <= '0;
          if (iters == '0) done_q <= 1'b1;
          else             st_q   <= ST_RD1;
        end
        ST_RD1: st_q <= ST_X1;
        ST_X1: begin
          c_q  <= c_w;
          st_q <= ST_RD2;
        end
        ST_RD2: st_q <= ST_X2;
        ST_X2: begin
          a_q   <= a_upd ^ mem_rdata;
          b_q   <= c_q;
          cnt_q <= cnt_q + 1'b1;
          if (last_iter) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_RD1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign final_a = a_q;
  assign final_b = b_q;
endmodule

// File: rtl/mixloop_core_chk.sv
module mixloop_core_chk #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  iters,
  input logic              busy,
  input logic              done,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [127:0]      final_a,
  input logic [127:0]      final_b,
  input logic              wr_first,
  input logic              rd_second
);
  logic [CNT_W:0]   wr_cnt;
  logic [CNT_W-1:0] n_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      n_cap  <= '0;
    end else if (start && !busy) begin
      wr_cnt <= '0;
      n_cap  <= iters;
    end else if (mem_en && mem_we) begin
      wr_cnt <= wr_cnt + 1'b1;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R4
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> $past(mem_en && !mem_we));
  // R4
  wb_same_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_first |-> (mem_addr == $past(mem_addr)));
  // R5
  rd2_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_second |-> (mem_en && !mem_we && $past(mem_en && mem_we)));
  // R10
  hold_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(final_a) && $stable(final_b)));
  // R8
  write_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_cnt == {n_cap, 1'b0}));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);
endmodule

bind mixloop_core mixloop_core_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .iters(iters), .busy(busy), .done(done),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .final_a(final_a),
  .final_b(final_b), .wr_first(wr_first), .rd_second(rd_second)
);

// File: tb/mixloop_core_bench.sv
module mixloop_core_bench;
  localparam int AW = 6;
  localparam int CW = 16;
  localparam int NE = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] iters = '0;
  logic [127:0] init_a = '0, init_b = '0;
  logic busy, done, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [127:0] mem_wdata, mem_rdata, final_a, final_b;

  logic [127:0] mem [NE];
  logic [127:0] ref_mem [NE];
  logic [127:0] rdq;
  logic [7:0]   sbt [256];
  logic [63:0]  rng = 64'h9e3779b97f4a7c15;
  int checks = 0, errors = 0, wd = 0, coll = 0;

  always #5 clk = ~clk;

  mixloop_core #(.ADDR_W(AW), .CNT_W(CW)) u_mixloop_core (
    .clk(clk), .rst_n(rst_n), .start(start), .iters(iters), .init_a(init_a),
    .init_b(init_b), .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .final_a(final_a), .final_b(final_b)
  );

  always @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    else if (mem_en)      rdq <= mem[mem_addr];
  end
  assign mem_rdata = rdq;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: got hang, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] nxt();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  function automatic logic [7:0] tmul(input logic [7:0] p, input logic [7:0] q);
    logic [7:0] r = 0;
    logic [7:0] x = p;
    logic [7:0] y = q;
    while (y != 0) begin
      if (y[0]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return r;
  endfunction

  // R3: S-box from a searched inverse plus the affine step.
  task automatic build_sbox();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] inv = 0;
      logic [7:0] s = 8'h63;
      for (int w = 1; w < 256; w++) if (tmul(8'(v), 8'(w)) == 8'h01) inv = 8'(w);
      for (int k = 0; k < 5; k++) s ^= 8'((inv << k) | (inv >> (8 - k)));
      sbt[v] = s;
    end
  endtask

  function automatic logic [127:0] ref_round(input logic [127:0] x, input logic [127:0] k);
    logic [7:0] s [4][4];
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) s[r][c] = sbt[x[8*(4*c+r) +: 8]];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] acc = 0;
        for (int j = 0; j < 4; j++) begin
          int m = (j - r + 4) % 4;
          logic [7:0] co = (m == 0) ? 8'd2 : (m == 1) ? 8'd3 : 8'd1;
          acc ^= tmul(co, s[j][(c + j) % 4]);
        end
        o[8*(4*c+r) +: 8] = acc ^ k[8*(4*c+r) +: 8];
      end
    return o;
  endfunction

  task automatic run_ref(input int n, inout logic [127:0] a, inout logic [127:0] b);
    for (int it = 0; it < n; it++) begin
      int i1 = int'(a[4 +: AW]);
      logic [127:0] c = ref_round(ref_mem[i1], a);
      int i2;
      logic [127:0] y, p, an;
      ref_mem[i1] = b ^ c;
      i2 = int'(c[4 +: AW]);
      y = ref_mem[i2];
      p = {64'd0, c[63:0]} * {64'd0, y[63:0]};
      an = {a[127:64] + p[63:0], a[63:0] + p[127:64]};
      ref_mem[i2] = an;
      if (i1 == i2) coll++;
      a = an ^ y;
      b = c;
    end
  endtask

  task automatic fill(input bit zero);
    for (int i = 0; i < NE; i++) begin
      logic [127:0] v = zero ? 128'd0 : {nxt(), nxt()};
      mem[i] <= v;
      ref_mem[i] = v;
    end
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic [127:0] a0, input logic [127:0] b0, input bit inject);
    logic [127:0] ea = a0, eb = b0;
    int i2exp = int'(ref_round(ref_mem[a0[4 +: AW]], a0)[4 +: AW]);
    int cyc;
    int mism = 0;
    run_ref(n, ea, eb);
    init_a = a0; init_b = b0; iters = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    if (n > 0) begin
      check(busy == 1'b1, "R9 busy", 128'(busy), 128'd1);
      check(mem_en && !mem_we && mem_addr == a0[4 +: AW], "R2 first index", 128'(mem_addr), 128'(a0[4 +: AW]));
    end
    while (!done && cyc < 20 * n + 10) begin
      @(negedge clk); cyc++;
      if (cyc == 3) check(mem_en && !mem_we && int'(mem_addr) == i2exp, "R5 second index", 128'(mem_addr), 128'(i2exp));
      if (inject && cyc == 6) begin
        start = 1'b1; iters = 3; init_a = ~a0; init_b = ~b0;
      end
      if (inject && cyc == 7) start = 1'b0;
    end
    check(cyc == 4 * n + 1, "R8 latency", 128'(cyc), 128'(4 * n + 1));
    check(final_a == ea, "R3 R6 R7 R11 final_a", final_a, ea);
    check(final_b == eb, "R3 R7 final_b", final_b, eb);
    check(!busy, "R9 idle at done", 128'(busy), 128'd0);
    @(negedge clk);
    check(!done, "R9 single pulse", 128'(done), 128'd0);
    for (int i = 0; i < NE; i++) if (mem[i] !== ref_mem[i]) mism++;
    check(mism == 0, "R4 R6 memory image", 128'(mism), 128'd0);
    repeat (4) @(negedge clk);
    check(final_a == ea && final_b == eb, "R10 hold", final_a, ea);
  endtask

  initial begin
    build_sbox();
    @(negedge clk);
    check(!busy && !done && !mem_en && !mem_we && final_a == 0 && final_b == 0,
          "R1 reset", final_a, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_en && final_a == 0 && final_b == 0, "R1 after reset", final_b, 128'd0);
    // R8 zero count, then a sweep of small counts over fresh contents
    fill(0); run(0, {nxt(), nxt()}, {nxt(), nxt()}, 0);
    for (int n = 1; n <= 4; n++) begin
      fill(0); run(n, {nxt(), nxt()}, {nxt(), nxt()}, 0);
    end
    // R3 all-zero scratchpad and state
    fill(1); run(2, 128'd0, 128'd0, 0);
    // R11 start pulse mid-run
    fill(0); run(9, {nxt(), nxt()}, {nxt(), nxt()}, 1);
    // R5 forced collision: a = 0 selects entry 0, plant x whose round lands on 0
    fill(0);
    begin
      logic [127:0] x = {nxt(), nxt()};
      while (ref_round(x, 128'd0)[4 +: AW] != 0) x = {nxt(), nxt()};
      mem[0] <= x; ref_mem[0] = x;
      @(negedge clk);
      coll = 0;
      run(3, 128'd0, {nxt(), nxt()}, 0);
      check(coll > 0, "R5 collision reached", 128'(coll), 128'd1);
    end
    // R7 long chain
    fill(0); coll = 0; run(300, {nxt(), nxt()}, {nxt(), nxt()}, 0);
    $display("long run collisions: %0d", coll);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule